// File: doc/BRIEF.md
# Indexed Block-Transfer Configuration Register Target

This block is a serial two-wire bus target that holds a small bank of 8-bit configuration registers. The registers are reached through an indexed block protocol. Every write gives a starting register index, then a byte count, then that many data bytes. The data bytes land in consecutive registers.

A read first sets the index with a short write. A repeated start and the read address follow. The target then answers with a count byte, taken from a writable count register, and after it the register contents from the index onward.

Both bus lines are oversampled by the system clock through two-flop synchronizers. Start and stop are recognised from data-line edges while the clock line is high. The data line is open-drain: the target only ever pulls it low, through an output enable. Every register is presented in parallel on a flat output bus for the surrounding logic.

Top module: `i2cb_target`

## Requirements
- R1: After reset every register is 0x00 except three. Register 6 is 0x01, since its bits 3:0 hold the constant vendor code 0001. Register 7 is 0x22. Register 8 (the count register) is 0x0F. The data-line enable is 0.
- R2: An address byte of 0xD2 (write) or 0xD3 (read) is acknowledged by pulling the data line low during the ninth clock. Any other address byte is not acknowledged. Every further byte is then also left unacknowledged and unstored until the next start.
- R3: In a write, the first byte after the address is the starting index. Only its low log2(NREG) bits are used, so with the default of 16 registers 0x13 selects register 3. The second byte is the count X. The next X data bytes are stored in consecutive registers, and each of these bytes is acknowledged.
- R4: A data byte beyond the count X is not acknowledged and is not stored, and neither is any byte after it. With X = 0 the first data byte is already refused.
- R5: The register index advances by one after each stored or transmitted data byte and wraps from NREG-1 back to 0.
- R6: All of register 7 and bits 3:0 of register 6 are read-only. A write to them is acknowledged but leaves those bits unchanged. Bits 7:4 of register 6 take the written value.
- R7: After the read address 0xD3, the target sends the content of register 8 first. It then sends the registers starting at the current index, each byte MSB first.
- R8: On a read, a host acknowledge makes the target send the next byte. A host not-acknowledge makes the target release the data line and stay silent until the next start.
- R9: The target changes its data-line enable only while the clock line is low. The one exception is the release that follows a start or stop.
- R10: The index is kept across stops and repeated starts. A read that begins directly with 0xD3 continues from the register after the last one transferred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | Pull the data line low when 1 |
| regs_o | output | NREG*8 | All registers; register i at bits [8*i+7:8*i] |

## Verification
Some behaviours hold on every cycle and are checked by the embedded assertions. The data-line enable rises only after a clock-low transition and holds still while the clock is high (R9). The line stays released whenever the target is idle or has decided not to acknowledge (R2, R8). The protected register bits never move (R6).

Other behaviours depend on whole transactions, and only the bench scenarios can show them. These are the framing by count, refusal past the count, index wrap and persistence, the count-first read order, and silence after a foreign address or a host not-acknowledge.

// File: rtl/i2cb_pkg.sv
package i2cb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_RACK,
        ST_TX,
        ST_HACK
    } st_e;

    typedef enum logic [1:0] {
        PH_ADDR,
        PH_INDEX,
        PH_COUNT,
        PH_DATA
    } ph_e;

    typedef struct packed {
        st_e        st;
        ph_e        ph;
        logic       rd;
        logic       ack;
        logic       oe;
        logic [3:0] bits;
        logic [7:0] sh;
        logic [7:0] left;
        logic [7:0] idx;
    } ctl_t;

endpackage

// File: rtl/i2cb_sync.sv
module i2cb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl_o,
    output logic sda_lvl_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    logic [1:0] pin_in;
    logic [1:0] lvl;
    logic [1:0] prev_d, prev_q;

    assign pin_in = {sda_i, scl_i};

    for (genvar p = 0; p < 2; p++) begin : g_pin
        logic [STAGES-1:0] chain_d, chain_q;
        always_comb chain_d = {chain_q[STAGES-2:0], pin_in[p]};
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= chain_d;
        end
        assign lvl[p] = chain_q[STAGES-1];
    end

    always_comb prev_d = lvl;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 2'b11;
        else        prev_q <= prev_d;
    end

    assign scl_lvl_o  = lvl[0];
    assign sda_lvl_o  = lvl[1];
    assign scl_rise_o = lvl[0] & ~prev_q[0];
    assign scl_fall_o = ~lvl[0] & prev_q[0];
    assign start_o    = lvl[0] & prev_q[0] & prev_q[1] & ~lvl[1];
    assign stop_o     = lvl[0] & prev_q[0] & ~prev_q[1] & lvl[1];

endmodule

// File: rtl/i2cb_regbank.sv
module i2cb_regbank #(
    parameter int                  NREG    = 16,
    parameter logic [NREG*8-1:0]   RST_VEC = '0,
    parameter logic [NREG*8-1:0]   RO_VEC  = '0,
    localparam int                 IW      = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [IW-1:0]     wr_idx_i,
    input  logic [7:0]        wr_data_i,
    output logic [NREG*8-1:0] regs_o
);
    for (genvar r = 0; r < NREG; r++) begin : g_cell
        localparam logic [7:0] RO  = RO_VEC[r*8 +: 8];
        localparam logic [7:0] RST = RST_VEC[r*8 +: 8];
        logic [7:0] cell_d, cell_q;

        always_comb begin
            cell_d = cell_q;
            if (wr_en_i && wr_idx_i == IW'(r))
                cell_d = (wr_data_i & ~RO) | (cell_q & RO);
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cell_q <= RST;
            else        cell_q <= cell_d;
        end

        assign regs_o[r*8 +: 8] = cell_q;

        if (RO != 8'h00) begin : g_ro
            // R6: protected bits never change
            a_r6_ro_bits_stable: assert property (@(posedge clk) disable iff (!rst_n)
                $stable(cell_q & RO));
        end
    end

endmodule

// File: rtl/i2cb_target.sv
module i2cb_target #(
    parameter int         NREG     = 16,
    parameter logic [6:0] DEV_ADDR = 7'h69,
    parameter int         CNT_IDX  = 8,
    parameter int         ID_IDX   = 7,
    parameter int         VEND_IDX = 6,
    parameter logic [7:0] ID_VAL   = 8'h22,
    parameter logic [3:0] VEND_VAL = 4'h1,
    parameter logic [7:0] CNT_RST  = 8'h0F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    output logic [NREG*8-1:0] regs_o
);
    import i2cb_pkg::*;

    localparam int         IW       = $clog2(NREG);
    localparam logic [7:0] IDX_MASK = 8'(NREG - 1);

    function automatic logic [NREG*8-1:0] mk_rst();
        logic [NREG*8-1:0] v = '0;
        v[VEND_IDX*8 +: 4] = VEND_VAL;
        v[ID_IDX*8 +: 8]   = ID_VAL;
        v[CNT_IDX*8 +: 8]  = CNT_RST;
        return v;
    endfunction

    function automatic logic [NREG*8-1:0] mk_ro();
        logic [NREG*8-1:0] v = '0;
        v[VEND_IDX*8 +: 4] = 4'hF;
        v[ID_IDX*8 +: 8]   = 8'hFF;
        return v;
    endfunction

    localparam logic [NREG*8-1:0] RST_VEC = mk_rst();
    localparam logic [NREG*8-1:0] RO_VEC  = mk_ro();

    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_ev, stop_ev;
    logic wr_en;
    logic [NREG*8-1:0] regs_w;
    logic [7:0] regs_a [NREG];
    logic [7:0] rd_byte, cnt_byte, idx_inc;
    ctl_t d, q;

    i2cb_sync #(.STAGES(2)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_lvl_o  (scl_lvl),
        .sda_lvl_o  (sda_lvl),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_ev),
        .stop_o     (stop_ev)
    );

    i2cb_regbank #(.NREG(NREG), .RST_VEC(RST_VEC), .RO_VEC(RO_VEC)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_idx_i  (q.idx[IW-1:0]),
        .wr_data_i (q.sh),
        .regs_o    (regs_w)
    );

    for (genvar g = 0; g < NREG; g++) begin : g_view
        assign regs_a[g] = regs_w[g*8 +: 8];
    end

    assign rd_byte  = regs_a[q.idx[IW-1:0]];
    assign cnt_byte = regs_a[CNT_IDX];
    assign idx_inc  = (q.idx + 8'd1) & IDX_MASK;

    always_comb begin
        d     = q;
        wr_en = 1'b0;
        if (start_ev) begin
            d.st   = ST_RX;
            d.ph   = PH_ADDR;
            d.bits = '0;
            d.oe   = 1'b0;
        end else if (stop_ev) begin
            d.st = ST_IDLE;
            d.oe = 1'b0;
        end else begin
            case (q.st)
                ST_RX: begin
                    if (scl_rise && q.bits != 4'd8) begin
                        d.sh   = {q.sh[6:0], sda_lvl};
                        d.bits = q.bits + 4'd1;
                    end else if (scl_fall && q.bits == 4'd8) begin
                        d.st   = ST_RACK;
                        d.bits = '0;
                        d.ack  = 1'b0;
                        case (q.ph)
                            PH_ADDR: begin
                                if (q.sh[7:1] == DEV_ADDR) begin
                                    d.ack = 1'b1;
                                    d.rd  = q.sh[0];
                                    d.ph  = PH_INDEX;
                                end
                            end
                            PH_INDEX: begin
                                d.ack = 1'b1;
                                d.idx = q.sh & IDX_MASK;
                                d.ph  = PH_COUNT;
                            end
                            PH_COUNT: begin
                                d.ack  = 1'b1;
                                d.left = q.sh;
                                d.ph   = PH_DATA;
                            end
                            default: begin
                                if (q.left != 8'd0) begin
                                    d.ack  = 1'b1;
                                    wr_en  = 1'b1;
                                    d.idx  = idx_inc;
                                    d.left = q.left - 8'd1;
                                end
                            end
                        endcase
                        d.oe = d.ack;
                    end
                end
                ST_RACK: begin
                    if (scl_fall) begin
                        d.oe   = 1'b0;
                        d.bits = '0;
                        if (!q.ack) begin
                            d.st = ST_IDLE;
                        end else if (q.rd) begin
                            d.st = ST_TX;
                            d.sh = cnt_byte;
                            d.oe = ~cnt_byte[7];
                        end else begin
                            d.st = ST_RX;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (q.bits == 4'd7) begin
                            d.st = ST_HACK;
                            d.oe = 1'b0;
                        end else begin
                            d.sh   = {q.sh[6:0], 1'b0};
                            d.oe   = ~q.sh[6];
                            d.bits = q.bits + 4'd1;
                        end
                    end
                end
                ST_HACK: begin
                    if (scl_rise) begin
                        d.ack = ~sda_lvl;
                    end else if (scl_fall) begin
                        if (q.ack) begin
                            d.st   = ST_TX;
                            d.sh   = rd_byte;
                            d.oe   = ~rd_byte[7];
                            d.bits = '0;
                            d.idx  = idx_inc;
                        end else begin
                            d.st = ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, ph: PH_ADDR, rd: 1'b0, ack: 1'b0, oe: 1'b0,
                   bits: 4'd0, sh: 8'd0, left: 8'd0, idx: 8'd0};
        end else begin
            q <= d;
        end
    end

    assign sda_oe_o = q.oe;
    assign regs_o   = regs_w;

    // R9: pulling the line starts only after a clock-low transition
    a_r9_drive_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe_o) |-> $past(scl_fall));

    // R9: enable holds still while the clock line stays high
    a_r9_stable_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_lvl && $past(scl_lvl) && !$past(start_ev) && !$past(stop_ev))
            |-> $stable(sda_oe_o));

    // R8: an idle target never pulls the line
    a_r8_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE) |-> !sda_oe_o);

    // R2 / R4: a refused byte leaves the line released in its ack slot
    a_r2_nack_released: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_RACK && !q.ack) |-> !sda_oe_o);

endmodule

// File: tb/i2cb_target_test.sv
`timescale 1ns/1ps
module i2cb_target_test;
    localparam int NREG = 16;
    localparam int Q    = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic [NREG*8-1:0] regs;
    wire  sda_line = sda_m & ~sda_oe;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    i2cb_target uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_m),
        .sda_i    (sda_line),
        .sda_oe_o (sda_oe),
        .regs_o   (regs)
    );

    // {index, write data, expected readback}
    localparam logic [23:0] VEC [6] = '{
        {8'h03, 8'hA5, 8'hA5},
        {8'h07, 8'h55, 8'h22},
        {8'h06, 8'hFF, 8'hF1},
        {8'h13, 8'h3C, 8'h3C},
        {8'h0F, 8'h81, 8'h81},
        {8'h01, 8'h7E, 8'h7E}
    };

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [39:0] act, input logic [39:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] rg(input int i);
        return regs[i*8 +: 8];
    endfunction

    task automatic bus_start();
        sda_m = 1'b1; wq(Q);
        scl_m = 1'b1; wq(Q);
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b1; wq(Q);
        sda_m = 1'b1; wq(2*Q);
    endtask

    task automatic wbyte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wq(Q);
            scl_m = 1'b1; wq(Q);
            scl_m = 1'b0; wq(Q);
        end
        sda_m = 1'b1; wq(Q);
        scl_m = 1'b1; wq(Q);
        ack = ~sda_line;
        wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic rbyte(input logic host_ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq(Q);
            scl_m = 1'b1; wq(Q);
            b[i] = sda_line;
            wq(Q);
            scl_m = 1'b0;
        end
        sda_m = ~host_ack; wq(Q);
        scl_m = 1'b1; wq(2*Q);
        scl_m = 1'b0; wq(1);
        sda_m = 1'b1;
    endtask

    // acks: bit0 address, bit1 index, bit2 count, bit3+k data byte k
    task automatic wr_tx(input logic [7:0] idx, input logic [7:0] cnt, input int n,
                         input logic [31:0] dat, output logic [7:0] acks);
        logic a;
        acks = '0;
        bus_start();
        wbyte(8'hD2, a); acks[0] = a;
        wbyte(idx, a);   acks[1] = a;
        wbyte(cnt, a);   acks[2] = a;
        for (int k = 0; k < n; k++) begin
            wbyte(dat[31-8*k -: 8], a);
            acks[3+k] = a;
        end
        bus_stop();
    endtask

    // reads n bytes (count byte included), host acks all but the last
    task automatic rd_tx(input logic set_idx, input logic [7:0] idx, input int n,
                         output logic [39:0] bytes, output logic [2:0] acks);
        logic a;
        logic [7:0] b;
        bytes = '0;
        acks  = 3'b111;
        bus_start();
        if (set_idx) begin
            wbyte(8'hD2, a); acks[0] = a;
            wbyte(idx, a);   acks[1] = a;
            bus_start();
        end
        wbyte(8'hD3, a); acks[2] = a;
        for (int k = 0; k < n; k++) begin
            rbyte(k != n - 1, b);
            bytes[39-8*k -: 8] = b;
        end
        bus_stop();
    endtask

    initial begin
        logic [7:0]  acks;
        logic [2:0]  racks;
        logic [39:0] rb;
        logic [7:0]  b;
        logic        a;
        logic [NREG*8-1:0] snap;

        wq(5);
        rst_n = 1'b1;
        wq(5);

        // R1: reset contents and released line
        chk("R1 reset regs", 40'(regs[127:0] == 128'h0000_0000_0000_000F_2201_0000_0000_0000), 40'd1);
        chk("R1 reset sda_oe", 40'(sda_oe), 40'd0);

        // table walk: single-byte write then read back
        for (int v = 0; v < 6; v++) begin
            wr_tx(VEC[v][23:16], 8'd1, 1, {VEC[v][15:8], 24'h0}, acks);
            chk("R3 write acks", 40'(acks), 40'h0F);
            chk("R3 R6 stored value", 40'(rg(int'(VEC[v][19:16]))), 40'(VEC[v][7:0]));
            rd_tx(1'b1, VEC[v][23:16], 2, rb, racks);
            chk("R2 read path acks", 40'(racks), 40'h7);
            chk("R7 count then data", rb, {8'h0F, VEC[v][7:0], 24'h0});
        end

        // R5: block write wrapping from 14 through 15 to 0
        wr_tx(8'h0E, 8'd3, 3, 32'h1122_3300, acks);
        chk("R5 wrap write acks", 40'(acks), 40'h3F);
        chk("R5 reg14", 40'(rg(14)), 40'h11);
        chk("R5 reg15", 40'(rg(15)), 40'h22);
        chk("R5 reg0 after wrap", 40'(rg(0)), 40'h33);

        // count register rewrite
        wr_tx(8'h08, 8'd1, 1, 32'h0300_0000, acks);
        chk("R3 count reg write", 40'(rg(8)), 40'h03);

        // R7 R5 R8: block read with wrap, count byte first
        rd_tx(1'b1, 8'h0E, 4, rb, racks);
        chk("R7 block read", rb, 40'h03_11_22_33_00);

        // R8: after host NACK the target stays silent
        rbyte(1'b1, b);
        chk("R8 silent after nack", 40'(b), 40'hFF);
        bus_stop();

        // R10: read with no index continues after last transferred register (1)
        rd_tx(1'b0, 8'h00, 2, rb, racks);
        chk("R10 index kept", rb, {8'h03, 8'h7E, 24'h0});

        // R4: bytes past the count refused and not stored
        wr_tx(8'h04, 8'd2, 4, 32'h4455_6677, acks);
        chk("R4 acks past count", 40'(acks), 40'h1F);
        chk("R4 reg4", 40'(rg(4)), 40'h44);
        chk("R4 reg5", 40'(rg(5)), 40'h55);
        chk("R4 reg6 untouched", 40'(rg(6)), 40'hF1);

        // R4: zero count refuses first data byte
        wr_tx(8'h02, 8'd0, 1, 32'h9900_0000, acks);
        chk("R4 zero count acks", 40'(acks), 40'h07);
        chk("R4 zero count reg2", 40'(rg(2)), 40'h00);

        // R2: foreign address ignored until next start
        snap = regs;
        bus_start();
        wbyte(8'hA4, a);
        chk("R2 foreign address nack", 40'(a), 40'd0);
        wbyte(8'h02, a);
        chk("R2 following byte nack", 40'(a), 40'd0);
        wbyte(8'h5A, a);
        bus_stop();
        chk("R2 regs unchanged", 40'(regs == snap), 40'd1);
        chk("R9 line released at end", 40'(sda_oe), 40'd0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule